// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Unit

This block turns software register writes into inter-processor messages. Software first writes a destination word, then a command word holding the vector, the delivery mode and the control bits. The write to the command word is itself the launch: it produces exactly one message on a valid/ready output. The block expands destination shorthands into either an explicit target identifier or a broadcast flag with an optional exclude-self marker. It rejects reserved delivery modes.

While a message waits to be accepted, a pending bit in the command word reads as one, so software can poll it before issuing the next command. A command written while another is still pending is refused and does not disturb the message in flight. Refused commands are recorded in an error-status register. That register shows a snapshot of the recorded errors: each write to it publishes the errors gathered since the previous write and starts a fresh collection.

Top module: `ipi_cmd_unit`

## Requirements
- R1: After reset, msg_valid is 0, the pending bit (command word bit 12) reads 0 and the error-status register reads 0.
- R2: A write to address 0 (command word) while no message is pending, with a mode other than 3, raises msg_valid on the next cycle with exactly one message. The message carries vector = bits 7:0, mode = bits 10:8, logical = bit 11, level = bit 14 and trigger = bit 15 of the written word.
- R3: With shorthand (command bits 19:18) equal to 0, msg_dest is taken from bits 24 and up of the destination word, written at address 1 beforehand; msg_bcast and msg_excl_self are 0.
- R4: With shorthand 1, msg_dest equals self_id and msg_bcast is 0.
- R5: Shorthand 2 gives msg_bcast=1, msg_excl_self=0 and an all-ones msg_dest. Shorthand 3 gives msg_bcast=1, msg_excl_self=1 and msg_dest=self_id.
- R6: The pending bit (bit 12 of the command word read at address 0) reads 1 from the cycle after launch until the message is accepted, and reads 0 afterwards.
- R7: While msg_valid is 1 and msg_ready is 0, msg_valid stays 1 and all message fields hold their values.
- R8: A command write while a message is pending sends no additional message and leaves the pending message unchanged. It sets the send-reject error, which is error-status bit 0.
- R9: A command with mode 3 sends no message and leaves the pending bit at 0. It sets the illegal-mode error, which is error-status bit 1.
- R10: Reading address 2 returns the error snapshot. A write to address 2 (data ignored) replaces the snapshot with the errors gathered since the previous such write and clears the gathered set. Errors raised after a snapshot do not appear until the next write.
- R11: In mode 6 (startup) the vector field, which carries the start page number, is passed to msg_vector unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| self_id | input | ID_W | Identifier of the local processor |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 command, 1 destination, 2 error status |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Receiver accepts message |
| msg_vector | output | 8 | Message vector or start page |
| msg_mode | output | 3 | Delivery mode code |
| msg_logical | output | 1 | Logical destination mode |
| msg_level | output | 1 | Level assert bit |
| msg_trigger | output | 1 | Trigger mode bit |
| msg_dest | output | ID_W | Target identifier |
| msg_bcast | output | 1 | Message goes to all processors |
| msg_excl_self | output | 1 | Broadcast excludes the sender |

## Verification
The bench builds the block with ID_W at its default of 8. With that width the all-ones broadcast identifier 0xFF stays distinct from the self identifier and from the explicit destinations used, so a swapped shorthand branch shows up as a wrong msg_dest. Holding msg_ready low lets the bench catch the pending bit, the held message and a refused second command within one window. Back-to-back error-register writes separate the snapshot from the gathered set.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int WORD_W     = 32;
    localparam int VEC_W      = 8;
    localparam int MODE_W     = 3;
    localparam int VEC_LSB    = 0;
    localparam int MODE_LSB   = 8;
    localparam int LOGIC_BIT  = 11;
    localparam int PEND_BIT   = 12;
    localparam int LEVEL_BIT  = 14;
    localparam int TRIG_BIT   = 15;
    localparam int SH_LSB     = 18;
    localparam int DEST_LSB   = 24;
    localparam int ERR_W      = 2;
    localparam int ERR_BUSY   = 0;
    localparam int ERR_MODE   = 1;

    localparam logic [1:0] ADDR_CMD  = 2'd0;
    localparam logic [1:0] ADDR_DEST = 2'd1;
    localparam logic [1:0] ADDR_ERR  = 2'd2;

    localparam logic [MODE_W-1:0] MODE_RSVD = 3'd3;

    typedef enum logic [1:0] {
        SH_FIELD  = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

    typedef struct packed {
        logic [VEC_W-1:0]  vector;
        logic [MODE_W-1:0] mode;
        logic              logical;
        logic              level;
        logic              trig;
        logic              bcast;
        logic              excl;
    } msg_ctl_t;

endpackage

// File: rtl/ipi_dest_expand.sv
module ipi_dest_expand #(
    parameter int ID_W = 8
) (
    input  ipi_pkg::shorthand_e sh,
    input  logic [ID_W-1:0]     field_id,
    input  logic [ID_W-1:0]     self_id,
    output logic [ID_W-1:0]     dest,
    output logic                bcast,
    output logic                excl
);
    import ipi_pkg::*;

    always_comb begin
        dest  = field_id;
        bcast = 1'b0;
        excl  = 1'b0;
        unique case (sh)
            SH_FIELD: begin
                dest = field_id;
            end
            SH_SELF: begin
                dest = self_id;
            end
            SH_ALL: begin
                dest  = '1;
                bcast = 1'b1;
            end
            SH_OTHERS: begin
                dest  = self_id;
                bcast = 1'b1;
                excl  = 1'b1;
            end
            default: begin
                dest = field_id;
            end
        endcase
    end

endmodule

// File: rtl/ipi_err_status.sv
module ipi_err_status #(
    parameter int ERR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] raise,
    input  logic             snap,
    output logic [ERR_W-1:0] visible
);

    typedef struct packed {
        logic [ERR_W-1:0] gathered;
        logic [ERR_W-1:0] shown;
    } err_state_t;

    err_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (snap) begin
            st_d.shown    = st_q.gathered;
            st_d.gathered = raise;
        end else begin
            st_d.gathered = st_q.gathered | raise;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign visible = st_q.shown;

endmodule

// File: rtl/ipi_launch.sv
module ipi_launch #(
    parameter int ID_W = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [ID_W-1:0]                     self_id,
    input  logic                                wr_cmd,
    input  logic                                wr_dest,
    input  logic [ipi_pkg::WORD_W-1:0]          wdata,
    input  logic                                ready,
    output logic                                valid,
    output ipi_pkg::msg_ctl_t                   ctl,
    output logic [ID_W-1:0]                     dest,
    output logic [ipi_pkg::WORD_W-1:0]          cmd_word,
    output logic [ipi_pkg::WORD_W-1:0]          dest_word,
    output logic [ipi_pkg::ERR_W-1:0]           err_raise
);
    import ipi_pkg::*;

    typedef struct packed {
        logic [WORD_W-1:0] cmd;
        logic [WORD_W-1:0] dst;
        logic              valid;
        msg_ctl_t          ctl;
        logic [ID_W-1:0]   dest;
    } launch_state_t;

    launch_state_t st_d, st_q;

    logic [ID_W-1:0]   exp_dest;
    logic              exp_bcast;
    logic              exp_excl;
    logic [MODE_W-1:0] new_mode;

    assign new_mode = wdata[MODE_LSB +: MODE_W];

    ipi_dest_expand #(.ID_W(ID_W)) u_expand (
        .sh       (shorthand_e'(wdata[SH_LSB +: 2])),
        .field_id (st_q.dst[DEST_LSB +: ID_W]),
        .self_id  (self_id),
        .dest     (exp_dest),
        .bcast    (exp_bcast),
        .excl     (exp_excl)
    );

    always_comb begin
        st_d      = st_q;
        err_raise = '0;
        if (st_q.valid && ready) begin
            st_d.valid = 1'b0;
        end
        if (wr_dest) begin
            st_d.dst = wdata;
        end
        if (wr_cmd) begin
            if (st_q.valid) begin
                err_raise[ERR_BUSY] = 1'b1;
            end else begin
                st_d.cmd           = wdata;
                st_d.cmd[PEND_BIT] = 1'b0;
                if (new_mode == MODE_RSVD) begin
                    err_raise[ERR_MODE] = 1'b1;
                end else begin
                    st_d.valid       = 1'b1;
                    st_d.ctl.vector  = wdata[VEC_LSB +: VEC_W];
                    st_d.ctl.mode    = new_mode;
                    st_d.ctl.logical = wdata[LOGIC_BIT];
                    st_d.ctl.level   = wdata[LEVEL_BIT];
                    st_d.ctl.trig    = wdata[TRIG_BIT];
                    st_d.ctl.bcast   = exp_bcast;
                    st_d.ctl.excl    = exp_excl;
                    st_d.dest        = exp_dest;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cmd_word           = st_q.cmd;
        cmd_word[PEND_BIT] = st_q.valid;
    end

    assign dest_word = st_q.dst;
    assign valid     = st_q.valid;
    assign ctl       = st_q.ctl;
    assign dest      = st_q.dest;

endmodule

// File: rtl/ipi_cmd_unit.sv
module ipi_cmd_unit #(
    parameter int ID_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ID_W-1:0] self_id,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_addr,
    input  logic [31:0]     cfg_wdata,
    output logic [31:0]     cfg_rdata,
    output logic            msg_valid,
    input  logic            msg_ready,
    output logic [7:0]      msg_vector,
    output logic [2:0]      msg_mode,
    output logic            msg_logical,
    output logic            msg_level,
    output logic            msg_trigger,
    output logic [ID_W-1:0] msg_dest,
    output logic            msg_bcast,
    output logic            msg_excl_self
);
    import ipi_pkg::*;

    localparam int ERR_PAD = WORD_W - ERR_W;

    logic              wr_cmd, wr_dest, wr_err;
    msg_ctl_t          ctl;
    logic [WORD_W-1:0] cmd_word, dest_word;
    logic [ERR_W-1:0]  err_raise, err_shown;

    assign wr_cmd  = cfg_we && (cfg_addr == ADDR_CMD);
    assign wr_dest = cfg_we && (cfg_addr == ADDR_DEST);
    assign wr_err  = cfg_we && (cfg_addr == ADDR_ERR);

    ipi_launch #(.ID_W(ID_W)) u_launch (
        .clk       (clk),
        .rst_n     (rst_n),
        .self_id   (self_id),
        .wr_cmd    (wr_cmd),
        .wr_dest   (wr_dest),
        .wdata     (cfg_wdata),
        .ready     (msg_ready),
        .valid     (msg_valid),
        .ctl       (ctl),
        .dest      (msg_dest),
        .cmd_word  (cmd_word),
        .dest_word (dest_word),
        .err_raise (err_raise)
    );

    ipi_err_status #(.ERR_W(ERR_W)) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .raise   (err_raise),
        .snap    (wr_err),
        .visible (err_shown)
    );

    always_comb begin
        unique case (cfg_addr)
            ADDR_CMD:  cfg_rdata = cmd_word;
            ADDR_DEST: cfg_rdata = dest_word;
            ADDR_ERR:  cfg_rdata = {{ERR_PAD{1'b0}}, err_shown};
            default:   cfg_rdata = '0;
        endcase
    end

    assign msg_vector    = ctl.vector;
    assign msg_mode      = ctl.mode;
    assign msg_logical   = ctl.logical;
    assign msg_level     = ctl.level;
    assign msg_trigger   = ctl.trig;
    assign msg_bcast     = ctl.bcast;
    assign msg_excl_self = ctl.excl;

endmodule

// File: rtl/ipi_cmd_unit_chk.sv
module ipi_cmd_unit_chk #(
    parameter int ID_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_we,
    input logic [1:0]      cfg_addr,
    input logic [10:0]     wr_fields,
    input logic            rd_pend,
    input logic            msg_valid,
    input logic            msg_ready,
    input logic [7:0]      msg_vector,
    input logic [2:0]      msg_mode,
    input logic [ID_W-1:0] msg_dest,
    input logic            msg_bcast,
    input logic            msg_excl_self
);

    // R2: a free command write with a legal mode launches its vector
    a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 2'd0 && !msg_valid && wr_fields[10:8] != 3'd3)
        |=> (msg_valid && msg_vector == $past(wr_fields[7:0])));

    // R5: exclude-self only ever accompanies a broadcast
    a_r5_excl_bcast: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_excl_self) |-> msg_bcast);

    // R6: the polled pending bit mirrors the output valid
    a_r6_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == 2'd0) |-> (rd_pend == msg_valid));

    // R7: a stalled message holds
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector)
        && $stable(msg_mode) && $stable(msg_dest) && $stable(msg_bcast)));

    // R8: a command refused while busy does not relaunch after acceptance
    a_r8_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 2'd0 && msg_valid && msg_ready) |=> !msg_valid);

    // R9: reserved mode launches nothing
    a_r9_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 2'd0 && !msg_valid && wr_fields[10:8] == 3'd3)
        |=> !msg_valid);

endmodule

bind ipi_cmd_unit ipi_cmd_unit_chk #(.ID_W(ID_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_addr      (cfg_addr),
    .wr_fields     (cfg_wdata[10:0]),
    .rd_pend       (cfg_rdata[12]),
    .msg_valid     (msg_valid),
    .msg_ready     (msg_ready),
    .msg_vector    (msg_vector),
    .msg_mode      (msg_mode),
    .msg_dest      (msg_dest),
    .msg_bcast     (msg_bcast),
    .msg_excl_self (msg_excl_self)
);

// File: tb/ipi_cmd_unit_bench.sv
module ipi_cmd_unit_bench;

    localparam int ID_W = 8;
    localparam logic [ID_W-1:0] SELF = 8'h05;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [ID_W-1:0] self_id = SELF;
    logic            cfg_we = 1'b0;
    logic [1:0]      cfg_addr = 2'd0;
    logic [31:0]     cfg_wdata = '0;
    logic [31:0]     cfg_rdata;
    logic            msg_valid;
    logic            msg_ready = 1'b1;
    logic [7:0]      msg_vector;
    logic [2:0]      msg_mode;
    logic            msg_logical, msg_level, msg_trigger;
    logic [ID_W-1:0] msg_dest;
    logic            msg_bcast, msg_excl_self;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0]      vec;
        logic [2:0]      mode;
        logic            logical, level, trig;
        logic [ID_W-1:0] dest;
        logic            bcast, excl;
        string           tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    ipi_cmd_unit #(.ID_W(ID_W)) u_ipi_cmd_unit (
        .clk(clk), .rst_n(rst_n), .self_id(self_id), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
        .msg_mode(msg_mode), .msg_logical(msg_logical), .msg_level(msg_level),
        .msg_trigger(msg_trigger), .msg_dest(msg_dest), .msg_bcast(msg_bcast),
        .msg_excl_self(msg_excl_self)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_addr = 2'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #2;
        d = cfg_rdata;
    endtask

    function automatic logic [31:0] cmd(input logic [7:0] vec, input logic [2:0] mode,
        input logic [1:0] sh, input logic logical, input logic level, input logic trig);
        cmd = '0;
        cmd[7:0] = vec; cmd[10:8] = mode; cmd[11] = logical;
        cmd[14] = level; cmd[15] = trig; cmd[19:18] = sh;
    endfunction

    task automatic send(input logic [7:0] vec, input logic [2:0] mode, input logic [1:0] sh,
        input logic logical, input logic level, input logic trig,
        input logic [ID_W-1:0] dest, input logic bcast, input logic excl, input string tag);
        exp_t e;
        e.vec = vec; e.mode = mode; e.logical = logical; e.level = level; e.trig = trig;
        e.dest = dest; e.bcast = bcast; e.excl = excl; e.tag = tag;
        sb.push_back(e);
        wr(2'd0, cmd(vec, mode, sh, logical, level, trig));
    endtask

    task automatic drain(input string tag);
        repeat (3) @(negedge clk);
        check(sb.size() == 0, tag, sb.size(), 0);
    endtask

    // Monitor: compares each accepted message with the scoreboard head
    always begin
        @(negedge clk);
        #2;
        if (rst_n && msg_valid && msg_ready) begin
            if (sb.size() == 0) begin
                check(1'b0, "R8 unexpected message", {24'b0, msg_vector}, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(msg_vector == e.vec && msg_mode == e.mode && msg_logical == e.logical
                      && msg_level == e.level && msg_trigger == e.trig,
                      {e.tag, " fields"},
                      {13'b0, msg_trigger, msg_level, msg_logical, msg_mode, msg_vector},
                      {13'b0, e.trig, e.level, e.logical, e.mode, e.vec});
                check(msg_dest == e.dest && msg_bcast == e.bcast && msg_excl_self == e.excl,
                      {e.tag, " destination"},
                      {22'b0, msg_bcast, msg_excl_self, msg_dest},
                      {22'b0, e.bcast, e.excl, e.dest});
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check(msg_valid == 1'b0, "R1 valid after reset", msg_valid, 0);
        rd(2'd0, v); check(v[12] == 1'b0, "R1 pending after reset", v[12], 0);
        rd(2'd2, v); check(v == 0, "R1 error status after reset", v, 0);

        // R2, R3 explicit destination
        wr(2'd1, 32'h2A00_0000);
        rd(2'd1, v); check(v == 32'h2A00_0000, "R3 destination word readback", v, 32'h2A00_0000);
        send(8'h41, 3'd0, 2'd0, 1'b1, 1'b1, 1'b0, 8'h2A, 1'b0, 1'b0, "R2 R3 fixed");
        drain("R2 single message");
        // R4 self
        send(8'h55, 3'd1, 2'd1, 1'b0, 1'b0, 1'b1, SELF, 1'b0, 1'b0, "R4 self");
        drain("R4 drained");
        // R5 all and all-but-self
        send(8'h60, 3'd4, 2'd2, 1'b0, 1'b1, 1'b0, 8'hFF, 1'b1, 1'b0, "R5 all");
        drain("R5 all drained");
        send(8'h00, 3'd5, 2'd3, 1'b0, 1'b1, 1'b1, SELF, 1'b1, 1'b1, "R5 others");
        drain("R5 others drained");
        // R11 startup page
        send(8'h9A, 3'd6, 2'd0, 1'b0, 1'b1, 1'b0, 8'h2A, 1'b0, 1'b0, "R11 startup page");
        drain("R11 drained");
        rd(2'd0, v); check(v[12] == 1'b0, "R6 pending clear after accept", v[12], 0);

        // R6, R7, R8 stalled receiver
        @(negedge clk); msg_ready = 1'b0;
        send(8'h33, 3'd0, 2'd1, 1'b0, 1'b0, 1'b0, SELF, 1'b0, 1'b0, "R7 held message");
        rd(2'd0, v); check(v[12] == 1'b1, "R6 pending while stalled", v[12], 1);
        held = msg_vector;
        repeat (3) @(negedge clk);
        check(msg_valid && msg_vector == held, "R7 message holds", msg_vector, held);
        wr(2'd0, cmd(8'h77, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0));
        #2;
        check(msg_valid && msg_vector == 8'h33, "R8 pending message unchanged", msg_vector, 8'h33);
        wr(2'd2, 32'h0);
        rd(2'd2, v); check(v == 32'h1, "R8 send-reject error bit 0", v, 1);
        @(negedge clk); msg_ready = 1'b1;
        drain("R8 only one message");

        // R9, R10 reserved mode
        wr(2'd0, cmd(8'h12, 3'd3, 2'd0, 1'b0, 1'b0, 1'b0));
        #2;
        check(msg_valid == 1'b0, "R9 no message on reserved mode", msg_valid, 0);
        rd(2'd0, v); check(v[12] == 1'b0, "R9 pending stays clear", v[12], 0);
        rd(2'd2, v); check(v == 32'h1, "R10 snapshot unchanged before write", v, 1);
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, v); check(v == 32'h2, "R9 R10 illegal-mode error bit 1", v, 2);
        wr(2'd2, 32'h0);
        rd(2'd2, v); check(v == 32'h0, "R10 gathered set cleared", v, 0);
        drain("R9 nothing sent");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule